// File: doc/BRIEF.md
# Machine Status Register Write Legalizer

This block keeps three privileged control registers of a processor core: the 32-bit machine status word, the trap-vector base register and the ISA-description register. Software writes reach it as a single write strobe, a target select, a data word, a flag that marks a write made through the restricted supervisor window of the status word, and the privilege level of the writer. Each accepted write is changed into a legal value before it is stored. Fields that may not be written keep their old contents. Writes that would leave a register in an illegal state are dropped whole.

The status word's summary-dirty bit is computed again from the stored float and extension state on every write. When a write changes a field that affects address translation, the block raises a flush pulse that lasts one cycle. A small state machine produces this pulse. It has two states. ST_IDLE holds the flush output low. ST_FLUSH drives it high for the cycle after the write. Transition T_HIT moves from either state to ST_FLUSH when an accepted status write alters a translation field. Transition T_CLR moves from either state to ST_IDLE in any other cycle. A masked copy of the status word is always available as the supervisor-window read value.

Top module: `mstat_csr`

## Requirements
- R1: While reset is held and just after it is released, status_q reads 0x0000_1800 (previous-privilege field bits [12:11] = 2'b11, all else zero), tvec_q reads 0, isa_q reads ISA_RESET (default 0x4014_112D) and flush_o is low.
- R2: An accepted machine-view status write (wr_target = 0, wr_sview = 0) copies only these bits from wr_data: 1, 3, 5, 7, 8, 11, 12, 13, 14, 17, 18, 19, 20, 21, 22 (mask 0x007E_79AA). Every other bit keeps its previous value. The result is visible one cycle after the write edge.
- R3: After every accepted status write, bit 31 is 1 exactly when bits [14:13] are 2'b11 or bits [16:15] are 2'b11.
- R4: flush_o is high for exactly the one cycle that follows an accepted status write changing any of bits 19, 18, 17, 12 or 11 (mask 0x000E_1800). It is low in every other cycle.
- R5: sview_rd_o always equals status_q AND 0x800D_E133, which is bits 0, 1, 4, 5, 8, 13 to 16, 18, 19 and 31.
- R6: A supervisor-view status write (wr_sview = 1) first merges wr_data into the status word under mask 0x800D_E133. It then applies the R2 and R3 rules, so only bits 1, 5, 8, 13, 14, 18 and 19 can change, apart from bit 31.
- R7: A trap-vector write (wr_target = 1) stores wr_data whole when wr_data[1:0] is 0 (direct) or 1 (vectored). When wr_data[1:0] is 2 or 3, tvec_q does not change.
- R8: An ISA write (wr_target = 2) is dropped, leaving isa_q unchanged, when bit 8 (base integer) is clear or bit 4 (reduced base) is set.
- R9: An accepted ISA write stores wr_data AND ISA_SUPPORT (default 0x0014_112D) in bits [29:0]. Bit 3 (double float) is cleared when bit 5 (single float) is clear in that result. Bits [31:30] keep their previous value.
- R10: cur_priv encodes 0 as user, 1 as supervisor and 3 as machine. Machine-view status, trap-vector and ISA writes take effect only at privilege 3. Supervisor-view writes take effect at privilege 1 or 3. Any other write changes nothing and raises no flush.
- R11: When wr_en is low, or when wr_target is 3, no register changes and flush_o stays low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_target | input | 2 | 0 status, 1 trap vector, 2 ISA, 3 none |
| wr_sview | input | 1 | Status write goes through the supervisor window |
| wr_data | input | 32 | Write data word |
| cur_priv | input | 2 | Privilege of the writer |
| status_q | output | 32 | Stored status word |
| tvec_q | output | 32 | Stored trap-vector base |
| isa_q | output | 32 | Stored ISA word |
| flush_o | output | 1 | One-cycle translation flush pulse |
| sview_rd_o | output | 32 | Supervisor-window read value |

## Verification
The properties assume that every input settles before each rising edge and that cur_priv never takes the reserved value 2. The bench keeps to both rules: it changes its inputs only on falling edges and uses only privileges 0, 1 and 3. The properties also assume that reset is held for at least one edge before the design is observed. The bench holds reset for several cycles before its first write.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        TGT_STATUS = 2'd0,
        TGT_TVEC   = 2'd1,
        TGT_ISA    = 2'd2,
        TGT_NONE   = 2'd3
    } wr_tgt_e;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FLUSH = 1'b1
    } flush_st_e;

    // status field positions
    localparam int B_SD     = 31;
    localparam int B_FS_LO  = 13;
    localparam int B_XS_LO  = 15;
    localparam int B_PP_LO  = 11;

    localparam logic [XLEN-1:0] ST_WRITE_MASK = 32'h007E_79AA;
    localparam logic [XLEN-1:0] ST_SVIEW_MASK = 32'h800D_E133;
    localparam logic [XLEN-1:0] ST_FLUSH_MASK = 32'h000E_1800;
    localparam logic [XLEN-1:0] ST_RESET      = 32'h0000_1800;

    // ISA word bit positions
    localparam int ISA_B_I  = 8;
    localparam int ISA_B_E  = 4;
    localparam int ISA_B_F  = 5;
    localparam int ISA_B_D  = 3;
    localparam int MXL_W    = 2;

    localparam int TVEC_MODE_W = 2;

endpackage

// File: rtl/mstat_status_legal.sv
module mstat_status_legal
    import mstat_pkg::*;
(
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] data_i,
    input  logic            sview_i,
    output logic [XLEN-1:0] new_o,
    output logic            flush_hit_o
);

    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] written;
    logic            dirty;

    // supervisor window merge, then the full-view write rule per bit
    genvar b;
    generate
        for (b = 0; b < XLEN; b++) begin : g_bit
            always_comb begin
                logic m;
                if (sview_i) begin
                    m = ST_SVIEW_MASK[b] ? data_i[b] : old_i[b];
                end else begin
                    m = data_i[b];
                end
                merged[b]  = m;
                written[b] = ST_WRITE_MASK[b] ? merged[b] : old_i[b];
            end
        end
    endgenerate

    always_comb begin
        dirty = (written[B_FS_LO +: 2] == 2'b11) ||
                (written[B_XS_LO +: 2] == 2'b11);
        new_o        = written;
        new_o[B_SD]  = dirty;
        flush_hit_o  = |((new_o ^ old_i) & ST_FLUSH_MASK);
    end

endmodule

// File: rtl/mstat_tvec_legal.sv
module mstat_tvec_legal
    import mstat_pkg::*;
(
    input  logic [XLEN-1:0] data_i,
    output logic            accept_o
);

    localparam logic [TVEC_MODE_W-1:0] MODE_LIMIT = TVEC_MODE_W'(2);

    always_comb begin
        accept_o = (data_i[TVEC_MODE_W-1:0] < MODE_LIMIT);
    end

endmodule

// File: rtl/mstat_isa_legal.sv
module mstat_isa_legal
    import mstat_pkg::*;
#(
    parameter logic [XLEN-1:0] SUPPORT = 32'h0014_112D
) (
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] data_i,
    output logic            accept_o,
    output logic [XLEN-1:0] new_o
);

    localparam int LOW_W = XLEN - MXL_W;

    logic [XLEN-1:0] masked;

    always_comb begin
        accept_o = data_i[ISA_B_I] && !data_i[ISA_B_E];
        masked   = data_i & SUPPORT;
        if (!masked[ISA_B_F]) begin
            masked[ISA_B_D] = 1'b0;
        end
        new_o = {old_i[XLEN-1 -: MXL_W], masked[LOW_W-1:0]};
    end

endmodule

// File: rtl/mstat_csr.sv
module mstat_csr
    import mstat_pkg::*;
#(
    parameter logic [XLEN-1:0] ISA_SUPPORT = 32'h0014_112D,
    parameter logic [XLEN-1:0] ISA_RESET   = 32'h4014_112D
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_target,
    input  logic            wr_sview,
    input  logic [XLEN-1:0] wr_data,
    input  logic [1:0]      cur_priv,
    output logic [XLEN-1:0] status_q,
    output logic [XLEN-1:0] tvec_q,
    output logic [XLEN-1:0] isa_q,
    output logic            flush_o,
    output logic [XLEN-1:0] sview_rd_o
);

    wr_tgt_e   tgt;
    priv_e     priv;
    flush_st_e state_q, state_d;

    logic            mach_ok, sup_ok;
    logic            st_we, tv_we, isa_we;
    logic [XLEN-1:0] st_new;
    logic            st_flush_hit;
    logic            tv_accept;
    logic            isa_accept;
    logic [XLEN-1:0] isa_new;

    assign tgt  = wr_tgt_e'(wr_target);
    assign priv = priv_e'(cur_priv);

    mstat_status_legal u_status (
        .old_i       (status_q),
        .data_i      (wr_data),
        .sview_i     (wr_sview),
        .new_o       (st_new),
        .flush_hit_o (st_flush_hit)
    );

    mstat_tvec_legal u_tvec (
        .data_i   (wr_data),
        .accept_o (tv_accept)
    );

    mstat_isa_legal #(
        .SUPPORT (ISA_SUPPORT)
    ) u_isa (
        .old_i    (isa_q),
        .data_i   (wr_data),
        .accept_o (isa_accept),
        .new_o    (isa_new)
    );

    // privilege gating and write decode
    always_comb begin
        mach_ok = (priv == PRIV_MACH);
        sup_ok  = (priv == PRIV_MACH) || (priv == PRIV_SUPER);
        st_we   = 1'b0;
        tv_we   = 1'b0;
        isa_we  = 1'b0;
        if (wr_en) begin
            unique case (tgt)
                TGT_STATUS: st_we  = wr_sview ? sup_ok : mach_ok;
                TGT_TVEC:   tv_we  = mach_ok && tv_accept;
                TGT_ISA:    isa_we = mach_ok && isa_accept;
                TGT_NONE:   ;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_RESET;
            tvec_q   <= '0;
            isa_q    <= ISA_RESET;
        end else begin
            if (st_we)  status_q <= st_new;
            if (tv_we)  tvec_q   <= wr_data;
            if (isa_we) isa_q    <= isa_new;
        end
    end

    // flush state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // flush state machine: next state and outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = (st_we && st_flush_hit) ? ST_FLUSH : ST_IDLE;
            ST_FLUSH: state_d = (st_we && st_flush_hit) ? ST_FLUSH : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        flush_o    = (state_q == ST_FLUSH);
        sview_rd_o = status_q & ST_SVIEW_MASK;
    end

endmodule

// File: rtl/mstat_csr_chk.sv
module mstat_csr_chk
    import mstat_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [1:0]      wr_target,
    input logic            wr_sview,
    input logic [XLEN-1:0] wr_data,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] status_q,
    input logic [XLEN-1:0] tvec_q,
    input logic [XLEN-1:0] isa_q,
    input logic            flush_o,
    input logic [XLEN-1:0] sview_rd_o
);

    localparam logic [XLEN-1:0] SV_CHANGE = (ST_SVIEW_MASK & ST_WRITE_MASK) |
                                            (32'h1 << B_SD);

    a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status_q) && $stable(tvec_q) && $stable(isa_q) && !flush_o);

    a_r3_sd_summary: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[B_SD] == ((status_q[B_FS_LO +: 2] == 2'b11) ||
                           (status_q[B_XS_LO +: 2] == 2'b11)));

    a_r4_flush_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (((status_q ^ $past(status_q)) & ST_FLUSH_MASK) != '0));

    a_r4_change_gives_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (((status_q ^ $past(status_q)) & ST_FLUSH_MASK) != '0) |-> flush_o);

    a_r2_locked_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~ST_WRITE_MASK & ~(32'h1 << B_SD)) ==
        ($past(status_q) & ~ST_WRITE_MASK & ~(32'h1 << B_SD)));

    a_r5_view_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sview_rd_o & ~ST_SVIEW_MASK) == '0);

    a_r6_sview_limited: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_target == TGT_STATUS && wr_sview |=>
        (status_q & ~SV_CHANGE) == ($past(status_q) & ~SV_CHANGE));

    a_r7_tvec_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        tvec_q[1] == 1'b0);

    a_r7_tvec_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_target == TGT_TVEC && cur_priv == PRIV_MACH && !wr_data[1]
        |=> tvec_q == $past(wr_data));

    a_r9_mxl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(isa_q[XLEN-1 -: MXL_W]));

    a_r9_d_needs_f: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_target == TGT_ISA |=> (!isa_q[ISA_B_D] || isa_q[ISA_B_F] ||
                                           $stable(isa_q)));

    a_r10_user_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && cur_priv == PRIV_USER |=>
        $stable(status_q) && $stable(tvec_q) && $stable(isa_q) && !flush_o);

endmodule

bind mstat_csr mstat_csr_chk u_chk (.*);

// File: tb/mstat_csr_tb_top.sv
`timescale 1ns/1ps
module mstat_csr_tb_top;

    localparam logic [31:0] WR_M   = 32'h007E_79AA;
    localparam logic [31:0] SV_M   = 32'h800D_E133;
    localparam logic [31:0] FL_M   = 32'h000E_1800;
    localparam logic [31:0] ISA_SP = 32'h0014_112D;
    localparam logic [31:0] ISA_RV = 32'h4014_112D;

    typedef struct {
        logic [31:0] st;
        logic [31:0] tv;
        logic [31:0] is;
        logic        fl;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_target = 2'd3;
    logic        wr_sview = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  cur_priv = 2'd3;
    logic [31:0] status_q, tvec_q, isa_q, sview_rd_o;
    logic        flush_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sb_q[$];

    logic [31:0] m_st = 32'h0000_1800;
    logic [31:0] m_tv = '0;
    logic [31:0] m_is = ISA_RV;

    always #2.5 clk = ~clk;

    mstat_csr dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_target(wr_target),
        .wr_sview(wr_sview), .wr_data(wr_data), .cur_priv(cur_priv),
        .status_q(status_q), .tvec_q(tvec_q), .isa_q(isa_q),
        .flush_o(flush_o), .sview_rd_o(sview_rd_o)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected result
    task automatic drive(bit en, logic [1:0] tgt, bit sv, logic [1:0] pr,
                         logic [31:0] d, string req);
        exp_t e;
        logic [31:0] merged, ns, iv;
        bit fl = 1'b0;
        @(negedge clk);
        wr_en = en; wr_target = tgt; wr_sview = sv; cur_priv = pr; wr_data = d;
        if (en && tgt == 2'd0 && (sv ? (pr == 2'd3 || pr == 2'd1) : pr == 2'd3)) begin
            merged = sv ? ((m_st & ~SV_M) | (d & SV_M)) : d;
            ns = (m_st & ~WR_M) | (merged & WR_M);
            ns[31] = (ns[14:13] == 2'b11) || (ns[16:15] == 2'b11);
            fl = ((ns ^ m_st) & FL_M) != 0;
            m_st = ns;
        end
        if (en && tgt == 2'd1 && pr == 2'd3 && d[1:0] < 2) m_tv = d;
        if (en && tgt == 2'd2 && pr == 2'd3 && d[8] && !d[4]) begin
            iv = d & ISA_SP;
            if (!iv[5]) iv[3] = 1'b0;
            iv[31:30] = m_is[31:30];
            m_is = iv;
        end
        e.st = m_st; e.tv = m_tv; e.is = m_is; e.fl = fl; e.req = req;
        sb_q.push_back(e);
    endtask

    // monitor: compare just after each edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.req, "status", status_q, e.st);
            check(e.req, "tvec", tvec_q, e.tv);
            check(e.req, "isa", isa_q, e.is);
            check(e.req, "flush", {31'd0, flush_o}, {31'd0, e.fl});
            check("R5", "sview", sview_rd_o, e.st & SV_M);
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "reset status", status_q, 32'h0000_1800);
        check("R1", "reset tvec", tvec_q, 32'h0);
        check("R1", "reset isa", isa_q, ISA_RV);
        check("R1", "reset flush", {31'd0, flush_o}, 32'h0);
        rst_n = 1'b1;
        drive(0, 2'd0, 0, 2'd3, 32'hFFFF_FFFF, "R11");
        drive(1, 2'd0, 0, 2'd3, 32'hFFFF_FFFF, "R2");
        drive(0, 2'd0, 0, 2'd3, 32'h0, "R4");
        drive(1, 2'd0, 0, 2'd3, 32'h0, "R2");
        drive(1, 2'd0, 0, 2'd3, 32'h0000_6000, "R3");
        drive(1, 2'd0, 0, 2'd3, 32'h0000_0000, "R3");
        drive(1, 2'd0, 1, 2'd1, 32'hFFFF_FFFF, "R6");
        drive(1, 2'd0, 1, 2'd3, 32'h0000_0000, "R6");
        drive(1, 2'd0, 1, 2'd0, 32'hFFFF_FFFF, "R10");
        drive(1, 2'd0, 0, 2'd1, 32'hFFFF_FFFF, "R10");
        drive(1, 2'd0, 0, 2'd3, 32'h0008_0000, "R4");
        drive(1, 2'd0, 0, 2'd3, 32'h0000_0800, "R4");
        drive(1, 2'd0, 0, 2'd3, 32'h0000_0800, "R4");
        drive(1, 2'd1, 0, 2'd3, 32'h8000_0001, "R7");
        drive(1, 2'd1, 0, 2'd3, 32'h1234_5672, "R7");
        drive(1, 2'd1, 0, 2'd3, 32'h0000_0103, "R7");
        drive(1, 2'd1, 0, 2'd1, 32'h0000_0100, "R10");
        drive(1, 2'd1, 0, 2'd3, 32'h0000_0100, "R7");
        drive(1, 2'd2, 0, 2'd3, 32'h0000_0100, "R9");
        drive(1, 2'd2, 0, 2'd3, 32'hC000_012D, "R9");
        drive(1, 2'd2, 0, 2'd3, 32'h0000_0118, "R8");
        drive(1, 2'd2, 0, 2'd3, 32'h0000_002D, "R8");
        drive(1, 2'd2, 0, 2'd3, 32'h0000_0108, "R9");
        drive(1, 2'd2, 0, 2'd3, 32'hFFFF_FFEF, "R9");
        drive(1, 2'd3, 0, 2'd3, 32'h0000_0000, "R11");
        drive(0, 2'd3, 0, 2'd3, 32'h0000_0000, "R11");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule